// File: doc/BRIEF.md
# Pair-Reading General Register File

This block is the general register file of a 32-bit processor datapath: thirty-two words of 32 bits, one write port and two read ports. Index zero is tied to the constant zero, so it reads as zero whatever has been written to it. Each read port has its own select, `rdPairA` or `rdPairB`, that picks one of two ways to read.

In word mode a read port returns the selected register in the low half of its 64-bit bus, and the upper half is zero. In pair mode the port returns a 64-bit operand. Its low half comes from the addressed register and its high half from the register one index above. That index is taken modulo 32, so index 31 pairs with the zero register and gives register 31 extended with zeros. This lets a 32-bit value take part directly in 64-bit arithmetic.

Reads are combinational. Writes take effect on the rising clock edge. A read of an index that is being written in the same cycle returns the incoming data. The two ports are independent, so both may read in pair mode at once.

Top module: `pair_reg_file`

## Requirements
- R1: When `wrEn` is high at a rising edge and `rst` is low, `wrData` is stored at `wrAddr` (if nonzero). The value stays there until it is written again or reset, and it can be read on either port.
- R2: Index 0 always reads as zero in the low half. A write addressed to index 0 is dropped and produces no same-cycle bypass.
- R3: In pair mode with address n, bits 31:0 of the port's bus carry register n and bits 63:32 carry register (n+1) mod 32.
- R4: In pair mode with address 31, bits 63:32 come from index 0 and are therefore zero, while bits 31:0 carry register 31.
- R5: In word mode, bits 63:32 of the port's bus are zero.
- R6: Ports A and B decode independently; both may be in pair mode in the same cycle, with any two addresses.
- R7: While `wrEn` is high with a nonzero `wrAddr`, any half of either read bus whose source index equals `wrAddr` shows `wrData` in that same cycle.
- R8: A high `rst` at a rising edge clears every register to zero. It overrides a write requested in the same cycle, and it suppresses the same-cycle bypass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear |
| rdAddrA | input | 5 | Read index, port A |
| rdPairA | input | 1 | Port A: 1 = pair mode, 0 = word mode |
| rdAddrB | input | 5 | Read index, port B |
| rdPairB | input | 1 | Port B: 1 = pair mode, 0 = word mode |
| wrEn | input | 1 | Write request |
| wrAddr | input | 5 | Write index |
| wrData | input | 32 | Write value |
| rdDataA | output | 64 | Port A operand (high half nonzero only in pair mode) |
| rdDataB | output | 64 | Port B operand (high half nonzero only in pair mode) |

## Verification
The hardest situation to reach is a same-cycle write whose index matches the upper half of a pair read. A bypass error there only shows when the high-half source is the index being written, not the addressed one. The bench therefore fills the file with every write paired with a read on port B, in pair mode, at the index just below the write. That includes the wrap case, where a write to index 0 must not bypass into the high half of a pair read at 31. Full sweeps of every address in both modes on both ports then follow, with two distinct data patterns and a reset that collides with a write.

// File: rtl/prf_pkg.sv
package prf_pkg;
  localparam int PRF_ADDR_W   = 5;
  localparam int PRF_DATA_W   = 32;
  localparam int PRF_NUM_REGS = 1 << PRF_ADDR_W;
  localparam int PRF_NUM_RD   = 2;
  localparam int PRF_OP_W     = 2 * PRF_DATA_W;

  typedef logic [PRF_ADDR_W-1:0] regIdx_t;

  // strobes for one read port
  typedef struct packed {
    regIdx_t loIdx;
    regIdx_t hiIdx;
    logic    pairEn;
    logic    loByp;
    logic    hiByp;
  } rdCtl_t;

  // strobes for the write port
  typedef struct packed {
    regIdx_t idx;
    logic    commit;
  } wrCtl_t;
endpackage

// File: rtl/prf_ctrl.sv
module prf_ctrl
  import prf_pkg::*;
(
  input  logic    rst,
  input  regIdx_t rdAddr [PRF_NUM_RD],
  input  logic    rdPair [PRF_NUM_RD],
  input  logic    wrEn,
  input  regIdx_t wrAddr,
  output wrCtl_t  wrCtl,
  output rdCtl_t  rdCtl  [PRF_NUM_RD]
);
  logic commitNow;

  // index zero is never a write target; reset takes priority
  assign commitNow    = wrEn && !rst && (wrAddr != '0);
  assign wrCtl.commit = commitNow;
  assign wrCtl.idx    = wrAddr;

  for (genvar p = 0; p < PRF_NUM_RD; p++) begin : g_port
    regIdx_t nextIdx;
    // wraps 31 -> 0 by truncation
    assign nextIdx = regIdx_t'(rdAddr[p] + regIdx_t'(1));

    always_comb begin
      rdCtl[p].loIdx  = rdAddr[p];
      rdCtl[p].hiIdx  = nextIdx;
      rdCtl[p].pairEn = rdPair[p];
      rdCtl[p].loByp  = commitNow && (wrAddr == rdAddr[p]);
      rdCtl[p].hiByp  = commitNow && rdPair[p] && (wrAddr == nextIdx);
    end
  end
endmodule

// File: rtl/prf_datapath.sv
module prf_datapath
  import prf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  wrCtl_t                wrCtl,
  input  logic [PRF_DATA_W-1:0] wrData,
  input  rdCtl_t                rdCtl  [PRF_NUM_RD],
  output logic [PRF_OP_W-1:0]   rdData [PRF_NUM_RD]
);
  logic [PRF_DATA_W-1:0] regView [PRF_NUM_REGS];

  for (genvar g = 0; g < PRF_NUM_REGS; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign regView[g] = '0;
    end else begin : g_store
      logic [PRF_DATA_W-1:0] regQ;
      always_ff @(posedge clk) begin
        if (rst)
          regQ <= '0;
        else if (wrCtl.commit && (wrCtl.idx == regIdx_t'(g)))
          regQ <= wrData;
      end
      assign regView[g] = regQ;
    end
  end

  for (genvar p = 0; p < PRF_NUM_RD; p++) begin : g_read
    logic [PRF_DATA_W-1:0] loWord;
    logic [PRF_DATA_W-1:0] hiWord;
    always_comb begin
      loWord = rdCtl[p].loByp ? wrData : regView[rdCtl[p].loIdx];
      if (!rdCtl[p].pairEn)
        hiWord = '0;
      else if (rdCtl[p].hiByp)
        hiWord = wrData;
      else
        hiWord = regView[rdCtl[p].hiIdx];
    end
    assign rdData[p] = {hiWord, loWord};
  end
endmodule

// File: rtl/pair_reg_file.sv
module pair_reg_file
  import prf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [PRF_ADDR_W-1:0] rdAddrA,
  input  logic                  rdPairA,
  input  logic [PRF_ADDR_W-1:0] rdAddrB,
  input  logic                  rdPairB,
  input  logic                  wrEn,
  input  logic [PRF_ADDR_W-1:0] wrAddr,
  input  logic [PRF_DATA_W-1:0] wrData,
  output logic [PRF_OP_W-1:0]   rdDataA,
  output logic [PRF_OP_W-1:0]   rdDataB
);
  regIdx_t             rdAddrVec [PRF_NUM_RD];
  logic                rdPairVec [PRF_NUM_RD];
  logic [PRF_OP_W-1:0] rdDataVec [PRF_NUM_RD];
  wrCtl_t              wrCtl;
  rdCtl_t              rdCtl     [PRF_NUM_RD];

  assign rdAddrVec[0] = rdAddrA;
  assign rdAddrVec[1] = rdAddrB;
  assign rdPairVec[0] = rdPairA;
  assign rdPairVec[1] = rdPairB;

  prf_ctrl u_ctrl (
    .rst    (rst),
    .rdAddr (rdAddrVec),
    .rdPair (rdPairVec),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrCtl  (wrCtl),
    .rdCtl  (rdCtl)
  );

  prf_datapath u_dp (
    .clk    (clk),
    .rst    (rst),
    .wrCtl  (wrCtl),
    .wrData (wrData),
    .rdCtl  (rdCtl),
    .rdData (rdDataVec)
  );

  assign rdDataA = rdDataVec[0];
  assign rdDataB = rdDataVec[1];
endmodule

// File: rtl/pair_reg_file_chk.sv
module pair_reg_file_chk
  import prf_pkg::*;
(
  input logic                  clk,
  input logic                  rst,
  input logic [PRF_ADDR_W-1:0] rdAddrA,
  input logic                  rdPairA,
  input logic [PRF_ADDR_W-1:0] rdAddrB,
  input logic                  rdPairB,
  input logic                  wrEn,
  input logic [PRF_ADDR_W-1:0] wrAddr,
  input logic [PRF_DATA_W-1:0] wrData,
  input logic [PRF_OP_W-1:0]   rdDataA,
  input logic [PRF_OP_W-1:0]   rdDataB
);
  AST_ZERO_INDEX: assert property (@(posedge clk) disable iff (rst)
    (rdAddrA == '0) |-> (rdDataA[PRF_DATA_W-1:0] == '0)); // R2

  AST_WORD_HIGH_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !rdPairB |-> (rdDataB[PRF_OP_W-1:PRF_DATA_W] == '0)); // R5

  AST_WRAP_TOP: assert property (@(posedge clk) disable iff (rst)
    (rdPairA && (rdAddrA == '1)) |-> (rdDataA[PRF_OP_W-1:PRF_DATA_W] == '0)); // R4

  AST_PAIR_MATCHES_NEIGHBOUR: assert property (@(posedge clk) disable iff (rst)
    (rdPairA && !rdPairB && (rdAddrB == PRF_ADDR_W'(rdAddrA + 1'b1)))
      |-> (rdDataA[PRF_OP_W-1:PRF_DATA_W] == rdDataB[PRF_DATA_W-1:0])); // R3

  AST_BYPASS_LOW: assert property (@(posedge clk) disable iff (rst)
    (wrEn && (wrAddr != '0) && (rdAddrB == wrAddr))
      |-> (rdDataB[PRF_DATA_W-1:0] == wrData)); // R7

  AST_WRITE_STICKS: assert property (@(posedge clk) disable iff (rst)
    (wrEn && (wrAddr != '0)) |=>
      (!((rdAddrA == $past(wrAddr)) && !(wrEn && (wrAddr == rdAddrA)))
       || (rdDataA[PRF_DATA_W-1:0] == $past(wrData)))); // R1

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !wrEn) |-> ((rdDataA == '0) && (rdDataB == '0))); // R8
endmodule

bind pair_reg_file pair_reg_file_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .rdAddrA (rdAddrA),
  .rdPairA (rdPairA),
  .rdAddrB (rdAddrB),
  .rdPairB (rdPairB),
  .wrEn    (wrEn),
  .wrAddr  (wrAddr),
  .wrData  (wrData),
  .rdDataA (rdDataA),
  .rdDataB (rdDataB)
);

// File: tb/pair_reg_file_test.sv
`timescale 1ns/1ps
module pair_reg_file_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rdAddrA = '0;
  logic        rdPairA = 1'b0;
  logic [4:0]  rdAddrB = '0;
  logic        rdPairB = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [63:0] rdDataA;
  logic [63:0] rdDataB;

  logic [31:0] refMem [32];
  int vecCount = 0;
  int missCount = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pair_reg_file uut (.*);

  function automatic logic [31:0] modelWord(int idx);
    if (idx == 0) return 32'h0;
    if (wrEn && !rst && (wrAddr == 5'(idx))) return wrData;
    return refMem[idx];
  endfunction

  function automatic logic [63:0] modelOp(logic [4:0] a, logic pair);
    logic [31:0] hi;
    hi = pair ? modelWord(int'(5'(a + 5'd1))) : 32'h0;
    return {hi, modelWord(int'(a))};
  endfunction

  task automatic compare(string tag, logic [63:0] act, logic [63:0] exp);
    vecCount++;
    if (act !== exp) begin
      missCount++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string tagFor(logic [4:0] a, logic pair);
    if (a == 5'd0 && !pair) return "R2";
    if (pair && a == 5'd31) return "R4";
    if (pair) return "R3";
    return "R5";
  endfunction

  // drive at the falling edge, check mid-low-phase, commit model after
  task automatic step(logic we, logic [4:0] wa, logic [31:0] wd,
                      logic [4:0] aa, logic pa, logic [4:0] ab, logic pb,
                      string tagA, string tagB);
    @(negedge clk);
    wrEn = we; wrAddr = wa; wrData = wd;
    rdAddrA = aa; rdPairA = pa; rdAddrB = ab; rdPairB = pb;
    #1;
    compare(tagA, rdDataA, modelOp(aa, pa));
    compare(tagB, rdDataB, modelOp(ab, pb));
    if (we && wa != 5'd0) refMem[int'(wa)] = wd;
  endtask

  task automatic fill(logic [31:0] seed);
    for (int i = 0; i < 32; i++) begin
      logic [31:0] v;
      v = seed ^ (32'h01030507 * 32'(i + 1));
      // A reads the target in word mode, B reads pair just below it (R7)
      step(1'b1, 5'(i), v, 5'(i), 1'b0, 5'(i - 1), 1'b1,
           (i == 0) ? "R2" : "R7", "R7");
    end
  endtask

  task automatic sweep();
    for (int n = 0; n < 32; n++) begin
      // both ports in pair mode at once: R6
      step(1'b0, 5'd0, 32'h0, 5'(n), 1'b1, 5'(31 - n), 1'b1,
           tagFor(5'(n), 1'b1), "R6");
      step(1'b0, 5'd0, 32'h0, 5'(n), 1'b0, 5'(31 - n), 1'b0,
           tagFor(5'(n), 1'b0), "R1");
    end
  endtask

  task automatic doReset(logic withWrite);
    @(negedge clk);
    rst = 1'b1; wrEn = withWrite; wrAddr = 5'd5; wrData = 32'hDEAD_BEEF;
    @(negedge clk);
    rst = 1'b0; wrEn = 1'b0;
    for (int i = 0; i < 32; i++) refMem[i] = 32'h0;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) refMem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state R8
    sweep();
    fill(32'hA5C3_0F69);
    sweep();
    // write to index 0 with pair read at 31 on the same cycle: R2, R4
    step(1'b1, 5'd0, 32'hFFFF_FFFF, 5'd0, 1'b0, 5'd31, 1'b1, "R2", "R4");
    step(1'b0, 5'd0, 32'h0, 5'd0, 1'b1, 5'd31, 1'b1, "R2", "R4");
    fill(32'h5A3C_F096);
    sweep();
    // reset colliding with a write: R8
    doReset(1'b1);
    step(1'b0, 5'd0, 32'h0, 5'd5, 1'b1, 5'd4, 1'b1, "R8", "R8");
    sweep();
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      missCount++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end
endmodule